// File: doc/BRIEF.md
# UART Interrupt Status and Mask Controller

This block is the interrupt front end of a memory-mapped serial port. It watches the receive and transmit FIFO level indications, derives five live status flags, and latches them together with five receive-side event pulses into a sticky status register. Software clears the sticky bits with write-one-to-clear writes. The interrupt mask is never written directly. One register offset sets mask bits and another clears them, and the mask itself is read-only. A single level interrupt line is raised while any sticky bit is also enabled in the mask.

The register port is a plain single-cycle interface: byte address, write enable and write data, plus a combinational read data bus. The FIFOs, the serial shifters, baud generation and any bus protocol conversion live outside the block. The block also holds the programmable receive trigger level that the live "receive level reached" flag compares against.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The live status register at offset 0x2C reads bit 0 = receive count at or above the trigger level, bit 1 = receive count zero, bit 2 = receive count equal to the FIFO depth (16 by default), bit 3 = transmitter empty, bit 4 = transmitter full, with all higher bits zero. It follows the inputs and the trigger register combinationally.
- R2: On every clock edge out of reset, each high live status bit 4:0 is ORed into the same bit of the sticky status register.
- R3: The event pulses set sticky bits as follows: overrun at bit 5, framing error at bit 6, parity error at bit 7, receive timeout at bit 8 and modem status change at bit 9. Each is sampled at a clock edge.
- R4: A write to the sticky status register (offset 0x14) clears every bit written as one. Bits written as zero keep their value.
- R5: When a clear and a set of the same sticky bit fall in the same cycle, the bit ends up set.
- R6: A write to offset 0x08 ORs the written bits 9:0 into the mask.
- R7: A write to offset 0x0C clears the written bits 9:0 from the mask.
- R8: The mask is read at offset 0x10, and writes to that offset leave it unchanged.
- R9: The interrupt output is registered. It is high in the cycle after the one in which mask AND sticky status is nonzero.
- R10: A synchronous active-low reset clears the mask, the sticky status and the interrupt output, and sets the trigger level to 32.
- R11: The trigger level register at offset 0x20 holds the low 6 bits written and reads them back.
- R12: Reads of any other offset, including the write-only offsets 0x08 and 0x0C, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Combinational read data for `addr` |
| rx_count | input | 5 | Receive FIFO fill level |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| ovr_pulse | input | 1 | Receive overrun event |
| frame_err_pulse | input | 1 | Framing error event |
| parity_err_pulse | input | 1 | Parity error event |
| rx_timeout_pulse | input | 1 | Receive timeout event |
| modem_chg_pulse | input | 1 | Modem status change event |
| irq | output | 1 | Level interrupt, registered |

## Verification
The hardest state to reach from the ports is a sticky bit being cleared and set in the same cycle. A live flag re-arms its sticky bit on every edge, so any live input left high hides the effect of a clear. The stimulus therefore parks the FIFO inputs at a quiet level (count between zero and the trigger, neither transmit flag). It then issues the clear together with a timeout pulse, and separately together with a count at or above the trigger. Each vector reads a chosen register back in the same cycle, so the set-over-clear result is visible before later stimulus can change it.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants for the UART interrupt controller.
// Holds register offsets and status bit positions. The offsets and the
// bit order are visible to software and must not change.
package uart_irq_pkg;
    localparam int ADDR_W  = 8;
    localparam int LIVE_W  = 5;
    localparam int EVT_W   = 5;
    localparam int STAT_W  = LIVE_W + EVT_W;

    localparam logic [ADDR_W-1:0] OFS_MASK_SET = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STICKY   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_TRIG     = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_LIVE     = 8'h2C;

    localparam int B_RX_LVL   = 0;
    localparam int B_RX_EMPTY = 1;
    localparam int B_RX_FULL  = 2;
    localparam int B_TX_EMPTY = 3;
    localparam int B_TX_FULL  = 4;
endpackage

// File: rtl/uart_live_status.sv
// Module: uart_live_status
// Derives the five live status flags from the FIFO level inputs and the
// trigger level. Purely combinational. Assumes rx_count never exceeds DEPTH.
module uart_live_status
    import uart_irq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TRIG_W = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [TRIG_W-1:0] trig_lvl,
    input  logic              tx_empty,
    input  logic              tx_full,
    output logic [LIVE_W-1:0] live
);
    logic [31:0] cnt_ext;
    logic [31:0] trig_ext;

    // Widen both operands so the level compare is width independent.
    always_comb begin
        cnt_ext  = 32'(rx_count);
        trig_ext = 32'(trig_lvl);
    end

    // Assemble the live flags.
    always_comb begin
        live             = '0;
        live[B_RX_LVL]   = (cnt_ext >= trig_ext);
        live[B_RX_EMPTY] = (rx_count == '0);
        live[B_RX_FULL]  = (cnt_ext == 32'(DEPTH));
        live[B_TX_EMPTY] = tx_empty;
        live[B_TX_FULL]  = tx_full;
    end
endmodule

// File: rtl/uart_irq_mask.sv
// Module: uart_irq_mask
// Interrupt mask with separate set and clear strokes. There is no direct
// load path. Assumes at most one of set_we / clr_we is high per cycle.
module uart_irq_mask
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] bits,
    output logic [STAT_W-1:0] mask_q
);
    logic [STAT_W-1:0] set_v;
    logic [STAT_W-1:0] clr_v;

    // Gate the written bits by the selected stroke.
    always_comb begin
        set_v = set_we ? bits : '0;
        clr_v = clr_we ? bits : '0;
    end

    // Mask register: set bits, then remove cleared bits.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | set_v) & ~clr_v;
    end
endmodule

// File: rtl/uart_sticky_status.sv
// Module: uart_sticky_status
// Sticky status register with write-one-to-clear. A set in the same cycle
// as a clear wins. Also registers the level interrupt from mask AND sticky.
module uart_sticky_status
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_bits,
    input  logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] sticky_q,
    output logic              irq_q
);
    // One flop per status bit: set dominates clear.
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                sticky_q[i] <= 1'b0;
            else if (set_vec[i])
                sticky_q[i] <= 1'b1;
            else if (clr_we && clr_bits[i])
                sticky_q[i] <= 1'b0;
        end
    end

    // Registered interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(mask & sticky_q);
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: uart_irq_ctrl (top)
// Register front end of the UART interrupt logic: address decode, trigger
// level register, read mux, and the live/mask/sticky sub-blocks.
// Assumes single-cycle writes and a combinational read of rdata.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TRIG_W   = 6,
    parameter int TRIG_RST = 32,
    parameter int DATA_W   = 32,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              ovr_pulse,
    input  logic              frame_err_pulse,
    input  logic              parity_err_pulse,
    input  logic              rx_timeout_pulse,
    input  logic              modem_chg_pulse,
    output logic              irq
);
    logic [TRIG_W-1:0] trig_q;
    logic [LIVE_W-1:0] live;
    logic [EVT_W-1:0]  evt;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] sticky_q;
    logic              we_mset, we_mclr, we_sticky, we_trig;

    // Decode write strobes per register.
    always_comb begin
        we_mset   = wr_en && (addr == OFS_MASK_SET);
        we_mclr   = wr_en && (addr == OFS_MASK_CLR);
        we_sticky = wr_en && (addr == OFS_STICKY);
        we_trig   = wr_en && (addr == OFS_TRIG);
    end

    // Collect event pulses in sticky bit order (bits 5..9).
    always_comb begin
        evt     = {modem_chg_pulse, rx_timeout_pulse, parity_err_pulse,
                   frame_err_pulse, ovr_pulse};
        set_vec = {evt, live};
    end

    // Receive trigger level register.
    always_ff @(posedge clk) begin
        if (!rst_n)       trig_q <= TRIG_W'(TRIG_RST);
        else if (we_trig) trig_q <= wdata[TRIG_W-1:0];
    end

    uart_live_status #(.DEPTH(DEPTH), .TRIG_W(TRIG_W)) u_live (
        .rx_count (rx_count),
        .trig_lvl (trig_q),
        .tx_empty (tx_empty),
        .tx_full  (tx_full),
        .live     (live)
    );

    uart_irq_mask u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (we_mset),
        .clr_we (we_mclr),
        .bits   (wdata[STAT_W-1:0]),
        .mask_q (mask_q)
    );

    uart_sticky_status u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (we_sticky),
        .clr_bits (wdata[STAT_W-1:0]),
        .mask     (mask_q),
        .sticky_q (sticky_q),
        .irq_q    (irq)
    );

    // Read mux; unmapped and write-only offsets read zero.
    always_comb begin
        unique case (addr)
            OFS_LIVE:   rdata = DATA_W'(live);
            OFS_STICKY: rdata = DATA_W'(sticky_q);
            OFS_MASK:   rdata = DATA_W'(mask_q);
            OFS_TRIG:   rdata = DATA_W'(trig_q);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Module: uart_irq_ctrl_chk
// Temporal checks for uart_irq_ctrl, attached with bind. Observes the
// register port, the set vector and the mask/sticky state.
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic [STAT_W-1:0] set_vec,
    input logic [STAT_W-1:0] mask_q,
    input logic [STAT_W-1:0] sticky_q
);
    p_live_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec[LIVE_W-1:0]) |=>
            ((sticky_q[LIVE_W-1:0] & $past(set_vec[LIVE_W-1:0])) == $past(set_vec[LIVE_W-1:0])));

    p_event_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec[STAT_W-1:LIVE_W]) |=>
            ((sticky_q[STAT_W-1:LIVE_W] & $past(set_vec[STAT_W-1:LIVE_W])) == $past(set_vec[STAT_W-1:LIVE_W])));

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_STICKY) |=>
            ((sticky_q & $past(wdata[STAT_W-1:0] & ~set_vec)) == '0));

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_STICKY && (|(wdata[STAT_W-1:0] & set_vec))) |=>
            ((sticky_q & $past(wdata[STAT_W-1:0] & set_vec)) == $past(wdata[STAT_W-1:0] & set_vec)));

    p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MASK_SET) |=>
            ((mask_q & $past(wdata[STAT_W-1:0])) == $past(wdata[STAT_W-1:0])));

    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MASK_CLR) |=> ((mask_q & $past(wdata[STAT_W-1:0])) == '0));

    p_mask_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MASK) |=> $stable(mask_q));

    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(mask_q & sticky_q))));

    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && sticky_q == '0 && !irq));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq      (irq),
    .set_vec  (set_vec),
    .mask_q   (mask_q),
    .sticky_q (sticky_q)
);

// File: tb/tb_uart_irq_ctrl.sv
// Bench for uart_irq_ctrl: a vector table walked by one loop, then
// directed tests for reset and the trigger-level boundary.
module tb_uart_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [4:0]  rx_count = 5'd2;
    logic        tx_empty = 1'b0;
    logic        tx_full = 1'b0;
    logic [4:0]  evt = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    uart_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rx_count(rx_count), .tx_empty(tx_empty), .tx_full(tx_full),
        .ovr_pulse(evt[0]), .frame_err_pulse(evt[1]), .parity_err_pulse(evt[2]),
        .rx_timeout_pulse(evt[3]), .modem_chg_pulse(evt[4]), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  waddr;
        logic [31:0] wd;
        logic [4:0]  rxc;
        logic        txe;
        logic        txf;
        logic [4:0]  ev;
        logic [7:0]  chk;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h2C, 32'h0,   5'd0,  1'b0, 1'b0, 5'h00, 8'h2C, 32'h002, 1'b0, 8'd1},  // R1 empty flag
        '{1'b0, 8'h2C, 32'h0,   5'd16, 1'b1, 1'b0, 5'h00, 8'h14, 32'h00E, 1'b0, 8'd2},  // R2 full+txe latch
        '{1'b1, 8'h20, 32'h4,   5'd5,  1'b0, 1'b1, 5'h00, 8'h2C, 32'h011, 1'b0, 8'd1},  // R1 level vs new trigger
        '{1'b0, 8'h20, 32'h0,   5'd2,  1'b0, 1'b0, 5'h00, 8'h20, 32'h004, 1'b0, 8'd11}, // R11 trigger readback
        '{1'b1, 8'h08, 32'h004, 5'd2,  1'b0, 1'b0, 5'h00, 8'h10, 32'h004, 1'b0, 8'd6},  // R6 enable
        '{1'b0, 8'h10, 32'h0,   5'd2,  1'b0, 1'b0, 5'h00, 8'h10, 32'h004, 1'b1, 8'd9},  // R9 irq one clock later
        '{1'b1, 8'h08, 32'h300, 5'd2,  1'b0, 1'b0, 5'h00, 8'h10, 32'h304, 1'b1, 8'd6},  // R6 OR into mask
        '{1'b1, 8'h10, 32'h0FF, 5'd2,  1'b0, 1'b0, 5'h00, 8'h10, 32'h304, 1'b1, 8'd8},  // R8 mask write ignored
        '{1'b1, 8'h0C, 32'h004, 5'd2,  1'b0, 1'b0, 5'h00, 8'h10, 32'h300, 1'b1, 8'd7},  // R7 disable
        '{1'b0, 8'h14, 32'h0,   5'd2,  1'b0, 1'b0, 5'h00, 8'h14, 32'h01E, 1'b0, 8'd9},  // R9 irq drops
        '{1'b1, 8'h14, 32'h00A, 5'd2,  1'b0, 1'b0, 5'h00, 8'h14, 32'h014, 1'b0, 8'd4},  // R4 partial W1C
        '{1'b0, 8'h14, 32'h0,   5'd2,  1'b0, 1'b0, 5'h08, 8'h14, 32'h114, 1'b0, 8'd3},  // R3 timeout event
        '{1'b0, 8'h14, 32'h0,   5'd2,  1'b0, 1'b0, 5'h00, 8'h14, 32'h114, 1'b1, 8'd9},  // R9 irq rises
        '{1'b1, 8'h14, 32'h100, 5'd2,  1'b0, 1'b0, 5'h08, 8'h14, 32'h114, 1'b1, 8'd5},  // R5 event beats clear
        '{1'b1, 8'h14, 32'h3FF, 5'd2,  1'b0, 1'b0, 5'h00, 8'h14, 32'h000, 1'b1, 8'd4},  // R4 clear all
        '{1'b0, 8'h14, 32'h0,   5'd2,  1'b0, 1'b0, 5'h00, 8'h14, 32'h000, 1'b0, 8'd9},  // R9 irq falls
        '{1'b1, 8'h14, 32'h001, 5'd6,  1'b0, 1'b0, 5'h00, 8'h14, 32'h001, 1'b0, 8'd5},  // R5 live beats clear
        '{1'b0, 8'h3C, 32'h0,   5'd2,  1'b0, 1'b0, 5'h00, 8'h3C, 32'h000, 1'b0, 8'd12}, // R12 unmapped
        '{1'b0, 8'h08, 32'h0,   5'd2,  1'b0, 1'b0, 5'h00, 8'h0C, 32'h000, 1'b0, 8'd12}, // R12 write-only
        '{1'b0, 8'h14, 32'h0,   5'd2,  1'b0, 1'b0, 5'h1F, 8'h14, 32'h3E1, 1'b0, 8'd3},  // R3 all events
        '{1'b0, 8'h14, 32'h0,   5'd2,  1'b0, 1'b0, 5'h00, 8'h14, 32'h3E1, 1'b1, 8'd9}   // R9 timeout enabled
    };

    task automatic check(input int req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    // Read a register combinationally between edges.
    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic do_reset();
        logic [31:0] d;
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rx_count = 5'd2; tx_empty = 1'b0;
        tx_full = 1'b0; evt = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        peek(8'h10, d); check(10, "reset mask", d, 32'h0);
        peek(8'h14, d); check(10, "reset sticky", d, 32'h0);
        peek(8'h20, d); check(10, "reset trigger", d, 32'd32);
        check(10, "reset irq", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        logic [31:0] d;
        do_reset();  // R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].wr; addr = VECS[i].waddr; wdata = VECS[i].wd;
            rx_count = VECS[i].rxc; tx_empty = VECS[i].txe;
            tx_full = VECS[i].txf; evt = VECS[i].ev;
            @(posedge clk);
            #1;
            wr_en = 1'b0; evt = '0;
            peek(VECS[i].chk, d);
            check(int'(VECS[i].req), $sformatf("vector %0d rdata", i), d, VECS[i].exp_rd);
            check(9, $sformatf("vector %0d irq", i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
        end
        // R10: mid-run reset returns to the reset state.
        do_reset();
        // R1: level flag exactly at and just below the trigger.
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h20; wdata = 32'd7;
        @(negedge clk);
        wr_en = 1'b0; rx_count = 5'd7;
        peek(8'h2C, d); check(1, "count equals trigger", d, 32'h001);
        rx_count = 5'd6;
        peek(8'h2C, d); check(1, "count below trigger", d, 32'h000);
        rx_count = 5'd15;
        peek(8'h2C, d); check(1, "count depth-1 not full", d, 32'h001);
        // R11: only the low 6 bits are kept.
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h20; wdata = 32'hFFFF_FFC9;
        @(negedge clk);
        wr_en = 1'b0;
        peek(8'h20, d); check(11, "trigger width", d, 32'h09);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule